// File: doc/BRIEF.md
# CDC Bus Capture Stability Monitor

This block watches a clock domain crossing that moves a multi-bit bus from a slow source clock to a faster destination clock. The crossing retimes only a valid strobe through a chain of destination flops and captures the bus on the rising edge of the retimed strobe. The monitor rebuilds that retiming chain and the capture instant on its own. It emits the one-cycle capture pulse. At each capture it judges whether the bus held one value over the whole settle window, which spans `SYNC_LEN` destination periods. It keeps a history of the bus sampled on every destination edge, so a bus that changes and then returns to its old value inside the window is still caught.

A separate detector in the source domain flags a strobe that stays high on two back-to-back source edges. The crossing cannot carry that: the adjacent words fold into one transfer, and the crossing is only safe with at most one strobe every `SYNC_LEN+1` source cycles. Each domain keeps its own sticky error output, and no flag crosses between the domains. The inputs come straight from source-domain registers, so nothing is placed between them and the first destination flop. The monitor only observes, so it offers no ready and applies no back-pressure: the source strobe and bus are sampled whenever they occur.

Top module: `cdc_capture_monitor`

## Requirements
- R1: `dst_cap_valid` is high for exactly one destination cycle per strobe assertion, however many cycles the strobe stays high. It rises at the (`SYNC_LEN`+1)-th destination rising edge after the strobe is first seen high at a destination edge.
- R2: At each capture, `dst_stable` becomes 1 only if the bus value was identical at every destination edge from the first edge that saw the strobe up to and including the capture edge. Otherwise it becomes 0.
- R3: A bus that changes and then returns to its earlier value within the settle window, across at least one destination edge, makes `dst_stable` 0, even though the oldest and the newest samples agree.
- R4: `dst_stable` changes only on the capture edge and otherwise keeps its value, whatever the bus does. Its reset value is 1.
- R5: `dst_err` is set by any capture with `dst_stable` becoming 0. It stays 1 until `dst_rst`, which clears it to 0.
- R6: `src_abuse` is high for one source cycle following the second of two consecutive source edges at which `src_valid` is high.
- R7: `src_err` is set together with `src_abuse` and stays 1 until `src_rst` clears it. Neither reset affects the other domain's sticky flag.
- R8: `dst_rst` (synchronous, active high) clears the retiming chain, its delayed copy and `dst_cap_valid`. A strobe that has been removed while the reset was held produces no capture pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock |
| src_rst | input | 1 | Synchronous active-high source reset |
| src_valid | input | 1 | Registered source strobe that accompanies a new bus word |
| src_data | input | DATA_W | Registered source bus, as presented to the crossing |
| src_abuse | output | 1 | One-cycle flag: strobe high on two adjacent source edges |
| src_err | output | 1 | Sticky source-domain misuse flag |
| dst_clk | input | 1 | Destination clock, faster than the source clock |
| dst_rst | input | 1 | Synchronous active-high destination reset |
| dst_cap_valid | output | 1 | One-cycle pulse marking a capture |
| dst_stable | output | 1 | Verdict of the latest capture, 1 meaning steady |
| dst_err | output | 1 | Sticky destination-domain unstable-capture flag |

## Verification
Two functions can land on the same destination edge: the capture verdict, and the arrival of a new bus value in the history. The bench moves the bus change across every gap between destination edges around a strobe, including the last period before capture. There the change is visible only in the comparison of the current bus with the oldest history entry. It repeats the sweep with a short excursion that reverts, including one that spans the capture edge. For each offset the bench computes from the edge times whether any sampled edge saw a different value, and compares that against the verdict sampled just after the capture pulse rises.

// File: rtl/cdcm_pkg.sv
package cdcm_pkg;

  // Verdict held between captures.
  typedef enum logic {
    VERDICT_UNSTEADY = 1'b0,
    VERDICT_STEADY   = 1'b1
  } verdict_e;

  // Smallest retiming chain the monitor accepts.
  localparam int unsigned CDCM_MIN_STAGES = 1;

endpackage

// File: rtl/cdcm_src_rate.sv
module cdcm_src_rate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic valid_i,
  output logic abuse_o,
  output logic err_o
);

  logic prev_q;
  logic abuse_q;
  logic err_q;
  logic pair_hit;

  // Two adjacent high strobes fold into a single transfer downstream.
  assign pair_hit = valid_i & prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b0;
      abuse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      prev_q  <= valid_i;
      abuse_q <= pair_hit;
      err_q   <= err_q | pair_hit;
    end
  end

  assign abuse_o = abuse_q;
  assign err_o   = err_q;

  AST_ABUSE_ON_PAIR: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && prev_q) |=> (abuse_o && err_o)); // R6
  AST_ABUSE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!valid_i) |=> !abuse_o); // R6
  AST_SRC_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o); // R7

endmodule

// File: rtl/cdcm_valid_retimer.sv
module cdcm_valid_retimer #(
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic strobe_i,
  output logic capture_o,
  output logic cap_valid_o
);

  localparam int unsigned LAST = SYNC_LEN - 1;

  logic [SYNC_LEN-1:0] sync_q;
  logic                tail_q;
  logic                pulse_q;

  // First stage takes the crossing strobe with no logic in front of it.
  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q[0] <= 1'b0;
    else       sync_q[0] <= strobe_i;
  end

  for (genvar s = 1; s < SYNC_LEN; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) sync_q[s] <= 1'b0;
      else       sync_q[s] <= sync_q[s-1];
    end
  end

  // Capture instant: last stage high while its delayed copy is still low.
  assign capture_o = sync_q[LAST] & ~tail_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tail_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tail_q  <= sync_q[LAST];
      pulse_q <= capture_o;
    end
  end

  assign cap_valid_o = pulse_q;

  AST_CAP_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    cap_valid_o |=> !cap_valid_o); // R1
  AST_RST_CLEARS_PULSE: assert property (@(posedge clk_i)
    rst_i |=> (!cap_valid_o && !capture_o)); // R8

  initial begin
    AST_LEN_LEGAL: assert (SYNC_LEN >= cdcm_pkg::CDCM_MIN_STAGES); // R1
  end

endmodule

// File: rtl/cdcm_bus_tracker.sv
module cdcm_bus_tracker
  import cdcm_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              capture_i,
  output logic              stable_o,
  output logic              err_o
);

  localparam int unsigned OLDEST = SYNC_LEN - 1;

  logic [SYNC_LEN-1:0][DATA_W-1:0] hist_q;
  logic [SYNC_LEN-1:0]             agree;
  logic                            steady;
  verdict_e                        verdict_q;
  logic                            err_q;

  // History of the bus, one entry per destination edge.
  always_ff @(posedge clk_i) begin
    if (rst_i) hist_q[0] <= '0;
    else       hist_q[0] <= bus_i;
  end

  for (genvar h = 1; h < SYNC_LEN; h++) begin : g_hist
    always_ff @(posedge clk_i) begin
      if (rst_i) hist_q[h] <= '0;
      else       hist_q[h] <= hist_q[h-1];
    end
  end

  // Slot 0 compares the live bus against the oldest entry; the rest compare
  // every other entry against the newest, so a revert cannot hide.
  assign agree[0] = (hist_q[OLDEST] == bus_i);
  for (genvar a = 1; a < SYNC_LEN; a++) begin : g_agree
    assign agree[a] = (hist_q[a] == hist_q[0]);
  end

  assign steady = &agree;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      verdict_q <= VERDICT_STEADY;
      err_q     <= 1'b0;
    end else if (capture_i) begin
      verdict_q <= steady ? VERDICT_STEADY : VERDICT_UNSTEADY;
      err_q     <= err_q | ~steady;
    end
  end

  assign stable_o = (verdict_q == VERDICT_STEADY);
  assign err_o    = err_q;

  AST_VERDICT_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!capture_i) |=> $stable(stable_o)); // R4
  AST_UNSTEADY_MARKS: assert property (@(posedge clk_i) disable iff (rst_i)
    (capture_i && !steady) |=> (err_o && !stable_o)); // R5
  AST_DST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o); // R5
  AST_REVERT_CAUGHT: assert property (@(posedge clk_i) disable iff (rst_i)
    (capture_i && (hist_q[OLDEST] == bus_i) && (hist_q[0] != bus_i)) |=> !stable_o); // R3

endmodule

// File: rtl/cdc_capture_monitor.sv
module cdc_capture_monitor #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_abuse,
  output logic              src_err,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_cap_valid,
  output logic              dst_stable,
  output logic              dst_err
);

  logic capture;

  cdcm_src_rate u_src_rate (
    .clk_i   (src_clk),
    .rst_i   (src_rst),
    .valid_i (src_valid),
    .abuse_o (src_abuse),
    .err_o   (src_err)
  );

  cdcm_valid_retimer #(
    .SYNC_LEN (SYNC_LEN)
  ) u_retimer (
    .clk_i       (dst_clk),
    .rst_i       (dst_rst),
    .strobe_i    (src_valid),
    .capture_o   (capture),
    .cap_valid_o (dst_cap_valid)
  );

  cdcm_bus_tracker #(
    .DATA_W   (DATA_W),
    .SYNC_LEN (SYNC_LEN)
  ) u_tracker (
    .clk_i     (dst_clk),
    .rst_i     (dst_rst),
    .bus_i     (src_data),
    .capture_i (capture),
    .stable_o  (dst_stable),
    .err_o     (dst_err)
  );

  AST_PULSE_CARRIES_VERDICT: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (dst_cap_valid && !dst_stable) |-> dst_err); // R5

endmodule

// File: tb/cdc_capture_monitor_bench.sv
`timescale 1ns/1ps
module cdc_capture_monitor_bench;

  localparam int W   = 8;
  localparam int LEN = 3;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst = 1'b1;
  logic         dst_rst = 1'b1;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_abuse, src_err, dst_cap_valid, dst_stable, dst_err;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  cap_cnt = 0;
  bit  done    = 1'b0;
  bit  any_unst = 1'b0;

  cdc_capture_monitor #(.DATA_W(W), .SYNC_LEN(LEN)) u_cdc_capture_monitor (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid), .src_data(src_data),
    .src_abuse(src_abuse), .src_err(src_err),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_cap_valid(dst_cap_valid),
    .dst_stable(dst_stable), .dst_err(dst_err)
  );

  // 250 MHz destination clock: rising edges at 2 + 4k ns.
  always #2 dst_clk = ~dst_clk;
  // Source clock, 12 ns period, rising edges at 3 + 12k ns (never on a destination edge).
  initial begin
    #3;
    forever begin
      src_clk = 1'b1; #6;
      src_clk = 1'b0; #6;
    end
  end

  always @(negedge dst_clk) if (dst_cap_valid) cap_cnt++;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One strobe at t0 (1 ns after a source edge) with bus nv. At t0+d the bus moves
  // to av and, with rev set, back to nv 2 ns later. Destination edges that feed the
  // verdict are at t0+2, +6, +10 and +14 (the capture edge).
  task automatic run_trial(int d, bit rev, logic [W-1:0] nv, logic [W-1:0] av);
    bit exp_unst;
    int base;
    if (rev) begin
      exp_unst = 1'b0;
      for (int j = 0; j <= LEN; j++)
        if ((2 + 4*j) > d && (2 + 4*j) < d + 2) exp_unst = 1'b1;
    end else begin
      exp_unst = (d > 2) && (d < 2 + 4*LEN);
    end
    @(posedge src_clk); #1;
    base = cap_cnt;
    src_valid = 1'b1;
    src_data  = nv;
    fork
      begin
        #(d); src_data = av;
        if (rev) begin #2; src_data = nv; end
      end
      begin
        #12; src_valid = 1'b0;
      end
      begin
        #13;
        chk("R1 pulse not before capture edge", dst_cap_valid, 0);
        #2;
        any_unst = any_unst | exp_unst;
        chk("R1 pulse after capture edge", dst_cap_valid, 1);
        chk(rev ? "R3 revert verdict" : "R2 window verdict", dst_stable, !exp_unst);
        chk("R5 sticky unstable flag", dst_err, any_unst);
        #4;
        chk("R1 pulse lasts one cycle", dst_cap_valid, 0);
      end
    join
    #60;
    chk("R1 one pulse per strobe", cap_cnt - base, 1);
  endtask

  task automatic wiggle_bus(int expect_stable);
    int base = cap_cnt;
    for (int k = 0; k < 20; k++) begin
      #4; src_data = src_data + 8'd37;
      if (k % 5 == 4) chk("R4 verdict holds without capture", dst_stable, expect_stable);
    end
    #20;
    chk("R4 no pulse without strobe", cap_cnt - base, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge src_clk);
    src_rst = 1'b0;
    @(negedge dst_clk);
    dst_rst = 1'b0;
    #1;
    chk("R8 reset pulse low", dst_cap_valid, 0);
    chk("R4 reset verdict", dst_stable, 1);
    chk("R5 reset sticky", dst_err, 0);
    chk("R6 reset abuse", src_abuse, 0);
    chk("R7 reset sticky", src_err, 0);

    // Sweep the bus change and the short excursion across the window.
    for (int rv = 0; rv < 2; rv++)
      for (int d = 1; d <= 17; d += 2)
        run_trial(d, rv[0], 8'(16*d + rv + 1), 8'(~(16*d + rv + 1)));

    // Verdict held between captures (unstable then steady).
    run_trial(5, 1'b0, 8'h5A, 8'hA5);
    wiggle_bus(0);

    // Destination reset while a strobe is in flight.
    @(posedge src_clk); #1;
    base = cap_cnt;
    src_valid = 1'b1; src_data = 8'h33;
    #5;  dst_rst = 1'b1;
    #7;  src_valid = 1'b0;
    #5;  dst_rst = 1'b0;
    #43;
    chk("R8 no pulse for strobe cleared by reset", cap_cnt - base, 0);
    chk("R5 reset clears sticky", dst_err, 0);
    chk("R4 reset restores verdict", dst_stable, 1);
    any_unst = 1'b0;

    run_trial(1, 1'b0, 8'h11, 8'h22);
    wiggle_bus(1);

    // Strobe held for two source edges.
    @(posedge src_clk); #1;
    base = cap_cnt;
    src_valid = 1'b1; src_data = 8'hC3;
    #16; chk("R6 no abuse after first edge", src_abuse, 0);
    #8;  src_valid = 1'b0;
    #5;  chk("R6 abuse after second edge", src_abuse, 1);
    chk("R7 sticky set with abuse", src_err, 1);
    #12; chk("R6 abuse lasts one source cycle", src_abuse, 0);
    #59;
    chk("R7 sticky holds", src_err, 1);
    chk("R1 held strobe gives one pulse", cap_cnt - base, 1);
    chk("R2 held strobe steady", dst_stable, 1);
    chk("R7 destination sticky untouched by abuse", dst_err, 0);

    @(negedge src_clk); src_rst = 1'b1;
    @(negedge src_clk); src_rst = 1'b0;
    #1;
    chk("R7 source reset clears sticky", src_err, 0);
    chk("R6 source reset clears abuse", src_abuse, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule